// File: doc/BRIEF.md
# Synchronous Linear Burst Read Controller

This block is the read-side control of a NOR-style memory port. It watches chip enable, address valid, output enable and an asynchronous reset on a free-running clock. In burst operation it captures a start address, waits a configured number of clocks, and then presents one 16-bit word per clock from a linear address sequence. That sequence wraps inside an aligned block whose size is set by the burst length. A separate end-of-burst strobe marks the closing transfers.

A small computed read-only array supplies the data. The outputs are a data word with its own drive enable and a strobe with its own drive enable. A pad ring would turn these into tri-state pins. A configuration register is loaded through a strobe. It selects between plain asynchronous reads and burst reads, and it sets the burst length, the initial latency and the strobe timing.

Top module: `burst_read_ctrl`

## Requirements
- R1: While `rst_n` is low, `dq_oe` and `eob_oe` are 0. Reset returns the configuration to all zeros, which selects asynchronous access.
- R2: In asynchronous mode (configuration bit 0 = 0), `dq_oe` is high exactly when `ce_n` and `oe_n` are both low, and `dq_out` = W(`addr`). W(a) is the low 16 bits of a*0x9E37 + 0x1234. In this mode `adv_n` is ignored and `eob_oe` is 0.
- R3: A clock edge with `cfg_load` high stores `cfg_data`. The fields are: bit 0 selects burst mode. Bits 2:1 give the length code, where 0, 1, 2 and 3 mean 2, 4, 8 and 8 double-words, which is 4, 8, 16 and 16 transfers. Bits 5:3 give the latency, and values below 2 act as 2. Bit 6 set moves the end strobe one transfer earlier.
- R4: In burst mode, an edge with `ce_n` and `adv_n` both low latches `addr`. The data output stays floated until the first word appears just after the Lat-th edge following the last such edge.
- R5: Transfer k (starting at 0) of a burst with L transfers from address A carries W((A & ~(L-1)) | ((A+k) & (L-1))).
- R6: In burst mode with `ce_n` and `oe_n` low, `eob_oe` is 1 and `eob_n` is high. `eob_n` is low for exactly one clock: on transfer L-1, or on transfer L-2 when bit 6 is set.
- R7: Raising `oe_n` floats both `dq_oe` and `eob_oe` without pausing the burst. When `oe_n` is lowered again, the output shows the transfer that the clock count has reached.
- R8: `ce_n` high floats both outputs at once and ends the burst. When `ce_n` is lowered again without `adv_n`, the data output stays floated.
- R9: `adv_n` low during a burst drops it. The data output stays floated while `adv_n` is held low, and the last address latched starts the new burst.
- R10: After the final transfer, the last word stays on `dq_out` with `eob_n` high and the sequence does not restart. This lasts until a new `adv_n` pulse.
- R11: Asserting `rst_n` low in the middle of a burst floats both outputs at once. After reset the block answers in asynchronous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address valid, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| cfg_load | input | 1 | Configuration load strobe |
| cfg_data | input | 16 | Configuration value |
| dq_out | output | DATA_W | Read data |
| dq_oe | output | 1 | Drive enable for `dq_out` |
| eob_n | output | 1 | End-of-burst strobe, active low |
| eob_oe | output | 1 | Drive enable for `eob_n` |

## Verification
The bench builds the block with its defaults, an 8-bit address and a 16-bit word. With an 8-bit address, 16-transfer bursts can start at offsets inside a block, so the wrap back to the block base is observed in the middle of a burst rather than only at its end. Every length code except the duplicate one is exercised, along with latencies of 2, 3 and 5 and a zero latency field that must clamp. Bursts are cut by output enable, chip enable, a new address pulse and reset, each at a known transfer.

// File: rtl/burst_read_ctrl.sv
module burst_read_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              adv_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cfg_load,
  input  logic [15:0]       cfg_data,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              eob_n,
  output logic              eob_oe
);

  localparam int BEAT_W = 4;
  localparam int CFG_W  = 7;

  typedef enum logic [1:0] {S_IDLE, S_LAT, S_DATA, S_HOLD} state_t;

  state_t            st;
  logic [CFG_W-1:0]  cfg_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BEAT_W-1:0] beat;
  logic [2:0]        lat_cnt;

  logic              burst_mode;
  logic [BEAT_W-1:0] last_beat;
  logic [BEAT_W-1:0] eob_beat;
  logic [2:0]        lat_val;
  logic [ADDR_W-1:0] wrap_mask;
  logic [ADDR_W-1:0] cur_addr;
  logic              cfg_unused;

  function automatic logic [DATA_W-1:0] rom_word(input logic [ADDR_W-1:0] a);
    logic [31:0] t;
    t = 32'(a) * 32'h0000_9E37 + 32'h0000_1234;
    return t[DATA_W-1:0];
  endfunction

  assign cfg_unused = ^cfg_data[15:CFG_W];
  assign burst_mode = cfg_q[0];

  always_comb begin
    case (cfg_q[2:1])
      2'd0:    last_beat = BEAT_W'(3);
      2'd1:    last_beat = BEAT_W'(7);
      default: last_beat = BEAT_W'(15);
    endcase
  end

  assign eob_beat  = cfg_q[6] ? last_beat - BEAT_W'(1) : last_beat;
  assign lat_val   = (cfg_q[5:3] < 3'd2) ? 3'd2 : cfg_q[5:3];
  assign wrap_mask = ADDR_W'(last_beat);
  assign cur_addr  = (addr_q & ~wrap_mask) | ((addr_q + ADDR_W'(beat)) & wrap_mask);

  assign dq_out = rom_word(burst_mode ? cur_addr : addr);
  assign dq_oe  = rst_n && !ce_n && !oe_n &&
                  (!burst_mode || st == S_DATA || st == S_HOLD);
  assign eob_oe = rst_n && !ce_n && !oe_n && burst_mode;
  assign eob_n  = !(st == S_DATA && beat == eob_beat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      st      <= S_IDLE;
      addr_q  <= '0;
      beat    <= '0;
      lat_cnt <= '0;
    end else begin
      if (cfg_load) cfg_q <= cfg_data[CFG_W-1:0];
      if (!burst_mode || ce_n) begin
        st <= S_IDLE;
      end else if (!adv_n) begin
        addr_q  <= addr;
        lat_cnt <= lat_val;
        beat    <= '0;
        st      <= S_LAT;
      end else begin
        case (st)
          S_LAT: begin
            if (lat_cnt == 3'd1) st <= S_DATA;
            else lat_cnt <= lat_cnt - 3'd1;
          end
          S_DATA: begin
            if (beat == last_beat) st <= S_HOLD;
            else beat <= beat + BEAT_W'(1);
          end
          default: st <= st;
        endcase
      end
    end
  end

  // R3
  cfg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> cfg_q == $past(cfg_data[CFG_W-1:0]));

  // R6
  eob_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eob_oe && !eob_n && !cfg_load) |=> eob_n);

  // R7
  oe_no_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && !ce_n && adv_n && burst_mode && !cfg_load && beat != last_beat)
    |=> (st == S_DATA && beat == $past(beat) + BEAT_W'(1)));

  // R8
  ce_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> st == S_IDLE);

  // R9
  adv_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !adv_n && burst_mode && !cfg_load) |=> (st == S_LAT && !dq_oe));

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && !ce_n && adv_n && !cfg_load)
    |=> (st == S_HOLD && $stable(cur_addr) && eob_n));

  // R2
  async_eob_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_mode |-> !eob_oe);

endmodule

// File: tb/test_burst_read_ctrl.sv
module test_burst_read_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        ce_n = 1, adv_n = 1, oe_n = 0, cfg_load = 0;
  logic [7:0]  addr = '0;
  logic [15:0] cfg_data = '0;
  logic [15:0] dq_out;
  logic        dq_oe, eob_n, eob_oe;
  int n_chk = 0, n_bad = 0;

  burst_read_ctrl i_burst_read_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .oe_n(oe_n),
    .addr(addr), .cfg_load(cfg_load), .cfg_data(cfg_data),
    .dq_out(dq_out), .dq_oe(dq_oe), .eob_n(eob_n), .eob_oe(eob_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] w(input logic [7:0] a);
    logic [31:0] t;
    t = 32'(a) * 32'h9E37 + 32'h1234;
    return t[15:0];
  endfunction

  function automatic logic [7:0] seq(input logic [7:0] a, input int n, input int k);
    logic [7:0] m;
    m = 8'(n - 1);
    return (a & ~m) | ((a + 8'(k)) & m);
  endfunction

  function automatic logic [15:0] mk(input bit b, input logic [1:0] len,
                                     input logic [2:0] lat, input bit early);
    return {9'b0, early, lat, len, b};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic load_cfg(input logic [15:0] v);
    @(negedge clk); cfg_data = v; cfg_load = 1;
    @(negedge clk); cfg_load = 0;
  endtask

  task automatic idle();
    @(negedge clk); ce_n = 1; adv_n = 1; oe_n = 0;
    @(negedge clk);
  endtask

  task automatic launch(input logic [7:0] a, input string req);
    @(negedge clk); ce_n = 0; adv_n = 0; addr = a;
    @(negedge clk); adv_n = 1; #1;
    chk(req, dq_oe, 0);
  endtask

  task automatic latency(input int lat, input string req);
    for (int j = 1; j < lat; j++) begin
      @(negedge clk); #1;
      chk(req, dq_oe, 0);
      chk({req, " R6"}, {eob_oe, eob_n}, 2'b11);
    end
  endtask

  task automatic beat(input logic [7:0] a, input int n, input int k,
                      input bit early, input string req);
    @(negedge clk); #1;
    chk(req, dq_oe, 1);
    chk(req, dq_out, w(seq(a, n, k)));
    chk({req, " R6"}, eob_oe, 1);
    chk({req, " R6"}, eob_n, (k == (early ? n - 2 : n - 1)) ? 0 : 1);
  endtask

  task automatic t_reset();
    ce_n = 0; oe_n = 0; addr = 8'h21;
    repeat (2) @(negedge clk);
    #1;
    chk("R1 dq_oe in reset", dq_oe, 0);
    chk("R1 eob_oe in reset", eob_oe, 0);
    rst_n = 1;
  endtask

  task automatic t_async();
    @(negedge clk); ce_n = 0; oe_n = 0; adv_n = 0; addr = 8'h21; #1;
    chk("R2 async drive", dq_oe, 1);
    chk("R2 async data", dq_out, w(8'h21));
    chk("R1 R2 eob floated", eob_oe, 0);
    @(negedge clk); addr = 8'hC3; adv_n = 1; #1;
    chk("R2 async data", dq_out, w(8'hC3));
    @(negedge clk); oe_n = 1; #1;
    chk("R2 oe float", dq_oe, 0);
    idle();
  endtask

  task automatic t_basic();
    load_cfg(mk(1, 2'd0, 3'd2, 0));
    launch(8'h12, "R4 float");
    latency(2, "R4 latency");
    for (int k = 0; k < 4; k++) beat(8'h12, 4, k, 0, "R3 R5 short");
    idle();
  endtask

  task automatic t_long();
    load_cfg(mk(1, 2'd2, 3'd5, 1));
    launch(8'h37, "R4 float");
    latency(5, "R4 latency5");
    for (int k = 0; k < 16; k++) beat(8'h37, 16, k, 1, "R5 long wrap");
    idle();
  endtask

  task automatic t_clamp();
    load_cfg(mk(1, 2'd1, 3'd0, 0));
    launch(8'h45, "R3 clamp");
    latency(2, "R3 clamp latency");
    for (int k = 0; k < 8; k++) beat(8'h45, 8, k, 0, "R3 clamp data");
    idle();
  endtask

  task automatic t_oe_hold();
    load_cfg(mk(1, 2'd1, 3'd3, 0));
    launch(8'h50, "R4 float");
    latency(3, "R4 latency3");
    beat(8'h50, 8, 0, 0, "R7 first");
    @(negedge clk); oe_n = 1; #1;
    chk("R7 dq float", dq_oe, 0);
    chk("R7 eob float", eob_oe, 0);
    @(negedge clk); #1;
    chk("R7 dq float", dq_oe, 0);
    @(negedge clk); oe_n = 0; #1;
    chk("R7 resumed beat", dq_out, w(seq(8'h50, 8, 3)));
    chk("R7 resumed drive", dq_oe, 1);
    for (int k = 4; k < 8; k++) beat(8'h50, 8, k, 0, "R7 tail");
    for (int j = 0; j < 3; j++) begin
      @(negedge clk); #1;
      chk("R10 hold data", dq_out, w(seq(8'h50, 8, 7)));
      chk("R10 hold drive", dq_oe, 1);
      chk("R10 hold eob", eob_n, 1);
    end
    idle();
  endtask

  task automatic t_ce();
    load_cfg(mk(1, 2'd1, 3'd2, 0));
    launch(8'h60, "R4 float");
    latency(2, "R4 latency");
    beat(8'h60, 8, 0, 0, "R8 pre");
    beat(8'h60, 8, 1, 0, "R8 pre");
    @(negedge clk); ce_n = 1; #1;
    chk("R8 dq float", dq_oe, 0);
    chk("R8 eob float", eob_oe, 0);
    @(negedge clk); ce_n = 0; #1;
    for (int j = 0; j < 3; j++) begin
      chk("R8 stays floated", dq_oe, 0);
      chk("R8 eob high", {eob_oe, eob_n}, 2'b11);
      @(negedge clk); #1;
    end
    idle();
  endtask

  task automatic t_adv();
    launch(8'h70, "R4 float");
    latency(2, "R4 latency");
    beat(8'h70, 8, 0, 0, "R9 pre");
    beat(8'h70, 8, 1, 0, "R9 pre");
    @(negedge clk); adv_n = 0; addr = 8'h83;
    @(negedge clk); addr = 8'h84; #1;
    chk("R9 float during adv", dq_oe, 0);
    @(negedge clk); adv_n = 1; #1;
    chk("R9 float after adv", dq_oe, 0);
    latency(2, "R9 latency");
    for (int k = 0; k < 8; k++) beat(8'h84, 8, k, 0, "R9 new burst");
    idle();
  endtask

  task automatic t_rst();
    launch(8'h90, "R4 float");
    latency(2, "R4 latency");
    beat(8'h90, 8, 0, 0, "R11 pre");
    #2 rst_n = 0; #1;
    chk("R11 dq float", dq_oe, 0);
    chk("R11 eob float", eob_oe, 0);
    @(negedge clk); rst_n = 1; addr = 8'h0F; #1;
    chk("R11 async after reset", dq_oe, 1);
    chk("R11 async data", dq_out, w(8'h0F));
    chk("R11 eob floated", eob_oe, 0);
    idle();
  endtask

  initial begin
    t_reset();
    t_async();
    t_basic();
    t_long();
    t_clamp();
    t_oe_hold();
    t_ce();
    load_cfg(mk(1, 2'd1, 3'd2, 0));
    t_adv();
    t_rst();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule